// File: doc/BRIEF.md
# MESI Coherence Line-State Controller

This block holds the coherence state of every line in one private cache and moves each line through the four MESI states: Modified, Exclusive, Shared and Invalid. The cache's own CPU side presents one read or write at a time, naming a line by its index. The block decides whether the access completes locally or needs the shared bus. If it needs the bus, it requests the bus and, once granted, issues a read miss, a write miss or an invalidate-only upgrade. The data array, tags and replacement policy are outside the block. Lines are addressed directly by index, so a miss means the line's state is Invalid.

At the same time the block snoops commands that other caches place on the bus. For a snooped read it asserts the wired shared signal whenever it holds a valid copy. When it holds the only dirty copy, it raises a flush strobe so that the line is written back and supplied to the requester. Snooped write misses and upgrades invalidate the local copy.

When this cache fills a line after its own read miss, the fill lands in Exclusive if no other cache drove the shared signal, and in Shared otherwise. A later write to an Exclusive line therefore needs no bus traffic at all.

Top module: `mesi_coherence`

## Requirements
- R1: Line states are encoded I=00, S=01, E=10, M=11 on `cpuState`. Reset leaves every line Invalid, so a snooped read of any line sees neither shared nor flush.
- R2: A CPU read of a line in S, E or M raises `cpuDone` in the cycle it is presented. It makes no bus request (`busReq`=0, `busCmd`=00), reports the unchanged state and leaves the state unchanged.
- R3: A CPU write to a line in E or M raises `cpuDone` in the cycle it is presented, with no bus request, and the line becomes M.
- R4: A CPU read of an Invalid line raises `busReq` from the next cycle until granted. In the cycle `busGnt` is high it drives `busCmd`=01 (read miss) with `busLine` and raises `cpuDone`. The line fills to E if `sharedIn` is low in that cycle and to S if it is high.
- R5: A CPU write to an Invalid line issues `busCmd`=10 (write miss) in its grant cycle, and the line ends in M.
- R6: A CPU write to a Shared line issues `busCmd`=11 (invalidate-only upgrade, no memory read) in its grant cycle, and the line ends in M.
- R7: A snooped read (`snpCmd`=01) of a line in S, E or M raises `snpShared` in the same cycle, and the line ends in S. `snpFlush` is raised only when the line was M.
- R8: A snooped write miss (10) or upgrade (11) of a line in S, E or M leaves it Invalid, with `snpFlush` raised only when the line was M and `snpShared` low.
- R9: A snoop of an Invalid line raises neither `snpShared` nor `snpFlush`, and the line stays Invalid.
- R10: When a snoop names the same line as the pending CPU access in the same cycle, the snoop takes effect first. The CPU access is held in that cycle (no `cpuDone`, no `busCmd`). The bus command is chosen from the line's state in the grant cycle, so a Shared line invalidated while its upgrade waits issues a write miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | CPU access pending; held until `cpuDone` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuLine | input | $clog2(NUM_LINES) | Line index of the CPU access |
| cpuDone | output | 1 | Access completes this cycle |
| cpuState | output | 2 | Line state after the access, valid with `cpuDone` |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant from the arbiter |
| busCmd | output | 2 | Issued command: 00 none, 01 read miss, 10 write miss, 11 upgrade |
| busLine | output | $clog2(NUM_LINES) | Line index of the issued command |
| sharedIn | input | 1 | Wired shared signal from other caches during own read miss |
| snpValid | input | 1 | Remote bus command present |
| snpCmd | input | 2 | Remote command, same encoding as `busCmd` |
| snpLine | input | $clog2(NUM_LINES) | Line index of the remote command |
| snpShared | output | 1 | This cache holds a valid copy of a snooped read line |
| snpFlush | output | 1 | Dirty copy must be written back and supplied |

## Verification
The bench builds the block with NUM_LINES=8. Random CPU accesses and snoops then revisit the same lines often, so every line passes through all four states and every pair of state and operation occurs many times. Grant delays of zero to three cycles and random shared-signal values cover both fill outcomes and the waiting path. Directed sequences add the same-line collision, including an upgrade whose line is invalidated while it waits.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_UPG  = 2'b11
  } busCmd_t;

  // strobes from control to the state store for the CPU-side line
  typedef struct packed {
    logic setMod;
    logic fillExcl;
    logic fillShr;
  } lineStrobe_t;
endpackage

// File: rtl/mesi_line_store.sv
`timescale 1ns/1ps
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpuLine,
  input  lineStrobe_t      strb,
  input  logic             snpValid,
  input  busCmd_t          snpCmd,
  input  logic [IDX_W-1:0] snpLine,
  output lineState_t       cpuCur,
  output logic             snpShared,
  output logic             snpFlush,
  output logic             snpOnCpuLine
);
  lineState_t stateQ [NUM_LINES];
  lineState_t snpCur;
  lineState_t cpuNew;
  logic       cpuWe;
  logic       snpActive;

  assign cpuCur       = stateQ[cpuLine];
  assign snpCur       = stateQ[snpLine];
  assign snpActive    = snpValid && (snpCmd != CMD_NONE);
  assign snpOnCpuLine = snpActive && (snpLine == cpuLine);
  assign snpShared    = snpValid && (snpCmd == CMD_RD) && (snpCur != ST_I);
  assign snpFlush     = snpActive && (snpCur == ST_M);

  assign cpuWe = strb.setMod | strb.fillExcl | strb.fillShr;
  always_comb begin
    if (strb.setMod)        cpuNew = ST_M;
    else if (strb.fillExcl) cpuNew = ST_E;
    else                    cpuNew = ST_S;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    lineState_t regQ;
    lineState_t nxt;
    always_comb begin
      nxt = regQ;
      if (snpActive && (snpLine == IDX_W'(g))) begin
        if (snpCmd == CMD_RD) begin
          if (regQ != ST_I) nxt = ST_S;
        end else begin
          nxt = ST_I;
        end
      end
      if (cpuWe && (cpuLine == IDX_W'(g))) nxt = cpuNew;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regQ <= ST_I;
      else        regQ <= nxt;
    end
    assign stateQ[g] = regQ;
  end

  // checker-side capture of the previous snoop
  logic [IDX_W-1:0] snpLineQ;
  logic             snpInvQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snpLineQ <= '0;
      snpInvQ  <= 1'b0;
    end else begin
      snpLineQ <= snpLine;
      snpInvQ  <= snpValid && ((snpCmd == CMD_WR) || (snpCmd == CMD_UPG));
    end
  end

  // R8
  snoop_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snpInvQ |-> (stateQ[snpLineQ] == ST_I));

  // R7
  flush_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snpFlush && (snpCmd == CMD_RD)) |-> snpShared);

  // R9
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snpValid && (snpCur == ST_I)) |-> (!snpShared && !snpFlush));
endmodule

// File: rtl/mesi_ctrl.sv
`timescale 1ns/1ps
module mesi_ctrl
  import mesi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpuValid,
  input  logic        cpuWrite,
  input  lineState_t  cpuCur,
  input  logic        snpOnCpuLine,
  input  logic        busGnt,
  input  logic        sharedIn,
  output logic        cpuDone,
  output lineState_t  doneState,
  output logic        busReq,
  output busCmd_t     busCmd,
  output lineStrobe_t strb
);
  typedef enum logic {PH_IDLE, PH_ARB} phase_t;
  phase_t  phaseQ, phaseNxt;
  logic    needBus;
  busCmd_t missCmd;

  always_comb begin
    needBus = cpuWrite ? ((cpuCur == ST_I) || (cpuCur == ST_S)) : (cpuCur == ST_I);
    if (!cpuWrite)            missCmd = CMD_RD;
    else if (cpuCur == ST_S)  missCmd = CMD_UPG;
    else                      missCmd = CMD_WR;
  end

  always_comb begin
    phaseNxt  = phaseQ;
    cpuDone   = 1'b0;
    busCmd    = CMD_NONE;
    strb      = '0;
    doneState = cpuCur;
    unique case (phaseQ)
      PH_IDLE: begin
        if (cpuValid && !snpOnCpuLine) begin
          if (!needBus) begin
            cpuDone = 1'b1;
            if (cpuWrite) begin
              strb.setMod = 1'b1;
              doneState   = ST_M;
            end
          end else begin
            phaseNxt = PH_ARB;
          end
        end
      end
      PH_ARB: begin
        if (cpuValid && busGnt && !snpOnCpuLine) begin
          busCmd   = missCmd;
          cpuDone  = 1'b1;
          phaseNxt = PH_IDLE;
          if (cpuWrite) begin
            strb.setMod = 1'b1;
            doneState   = ST_M;
          end else if (sharedIn) begin
            strb.fillShr = 1'b1;
            doneState    = ST_S;
          end else begin
            strb.fillExcl = 1'b1;
            doneState     = ST_E;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phaseQ <= PH_IDLE;
    else        phaseQ <= phaseNxt;
  end

  assign busReq = (phaseQ == PH_ARB);

  // R4
  cmd_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busCmd != CMD_NONE) |-> (busGnt && busReq));

  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && !busGnt && cpuValid) |=> busReq);

  // R10
  collision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snpOnCpuLine |-> (!cpuDone && (busCmd == CMD_NONE)));

  // R6
  upgrade_from_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busCmd == CMD_UPG) |-> (cpuWrite && (cpuCur == ST_S)));
endmodule

// File: rtl/mesi_coherence.sv
`timescale 1ns/1ps
module mesi_coherence
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpuValid,
  input  logic             cpuWrite,
  input  logic [IDX_W-1:0] cpuLine,
  output logic             cpuDone,
  output logic [1:0]       cpuState,
  output logic             busReq,
  input  logic             busGnt,
  output logic [1:0]       busCmd,
  output logic [IDX_W-1:0] busLine,
  input  logic             sharedIn,
  input  logic             snpValid,
  input  logic [1:0]       snpCmd,
  input  logic [IDX_W-1:0] snpLine,
  output logic             snpShared,
  output logic             snpFlush
);
  lineState_t  cpuCur, doneState;
  lineStrobe_t strb;
  busCmd_t     cmdOut;
  logic        snpOnCpuLine;

  mesi_line_store #(.NUM_LINES(NUM_LINES)) uStore (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpuLine      (cpuLine),
    .strb         (strb),
    .snpValid     (snpValid),
    .snpCmd       (busCmd_t'(snpCmd)),
    .snpLine      (snpLine),
    .cpuCur       (cpuCur),
    .snpShared    (snpShared),
    .snpFlush     (snpFlush),
    .snpOnCpuLine (snpOnCpuLine)
  );

  mesi_ctrl uCtrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpuValid     (cpuValid),
    .cpuWrite     (cpuWrite),
    .cpuCur       (cpuCur),
    .snpOnCpuLine (snpOnCpuLine),
    .busGnt       (busGnt),
    .sharedIn     (sharedIn),
    .cpuDone      (cpuDone),
    .doneState    (doneState),
    .busReq       (busReq),
    .busCmd       (cmdOut),
    .strb         (strb)
  );

  assign cpuState = doneState;
  assign busCmd   = cmdOut;
  assign busLine  = cpuLine;

  // R3
  local_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuDone && cpuWrite) |-> (cpuState == 2'b11));
endmodule

// File: tb/sim_mesi_coherence.sv
`timescale 1ns/1ps
module sim_mesi_coherence;
  localparam int NL = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpuValid = 0, cpuWrite = 0, busGnt = 0, sharedIn = 0, snpValid = 0;
  logic [IW-1:0] cpuLine = '0, snpLine = '0;
  logic [1:0] snpCmd = 2'b00;
  logic cpuDone, busReq, snpShared, snpFlush;
  logic [1:0] cpuState, busCmd;
  logic [IW-1:0] busLine;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [1:0] modelSt [NL];

  mesi_coherence #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuLine(cpuLine), .cpuDone(cpuDone), .cpuState(cpuState), .busReq(busReq),
    .busGnt(busGnt), .busCmd(busCmd), .busLine(busLine), .sharedIn(sharedIn),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpLine(snpLine),
    .snpShared(snpShared), .snpFlush(snpFlush)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit isHit(bit w, logic [1:0] s);
    return w ? s[1] : (s != 2'b00);
  endfunction

  function automatic logic [1:0] expCmd(bit w, logic [1:0] s);
    if (!w) return 2'b01;
    return (s == 2'b01) ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [1:0] snoopNext(logic [1:0] cmd, logic [1:0] s);
    if (s == 2'b00) return 2'b00;
    return (cmd == 2'b01) ? 2'b01 : 2'b00;
  endfunction

  task automatic cpuAccess(input bit w, input int line, input bit shr, input int gntDelay);
    logic [1:0] s;
    logic [1:0] fin;
    string req;
    s = modelSt[line];
    @(negedge clk);
    cpuValid = 1; cpuWrite = w; cpuLine = IW'(line); sharedIn = shr; busGnt = 0;
    #5;
    if (isHit(w, s)) begin
      req = w ? "R3" : "R2";
      fin = w ? 2'b11 : s;
      chk(cpuDone == 1'b1, req, cpuDone, 1);
      chk(busReq == 1'b0 && busCmd == 2'b00, req, {busReq, busCmd}, 0);
      chk(cpuState == fin, req, cpuState, fin);
    end else begin
      req = !w ? "R4" : ((s == 2'b01) ? "R6" : "R5");
      fin = w ? 2'b11 : (shr ? 2'b01 : 2'b10);
      chk(cpuDone == 1'b0, req, cpuDone, 0);
      for (int i = 0; i < gntDelay; i++) begin
        @(negedge clk); #5;
        chk(busReq == 1'b1 && busCmd == 2'b00 && cpuDone == 1'b0, req,
            {busReq, busCmd, cpuDone}, 4'b1000);
      end
      @(negedge clk); busGnt = 1; #5;
      chk(busReq == 1'b1, req, busReq, 1);
      chk(busCmd == expCmd(w, s), req, busCmd, expCmd(w, s));
      chk(busLine == IW'(line), req, busLine, line);
      chk(cpuDone == 1'b1 && cpuState == fin, req, {cpuDone, cpuState}, {1'b1, fin});
    end
    modelSt[line] = fin;
    @(negedge clk);
    cpuValid = 0; busGnt = 0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input int line);
    logic [1:0] s;
    string req;
    bit eShr, eFl;
    s = modelSt[line];
    if (s == 2'b00) req = "R9";
    else req = (cmd == 2'b01) ? "R7" : "R8";
    eShr = (cmd == 2'b01) && (s != 2'b00);
    eFl  = (s == 2'b11);
    @(negedge clk);
    snpValid = 1; snpCmd = cmd; snpLine = IW'(line);
    #5;
    chk(snpShared == eShr, req, snpShared, eShr);
    chk(snpFlush == eFl, req, snpFlush, eFl);
    modelSt[line] = snoopNext(cmd, s);
    @(negedge clk);
    snpValid = 0;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) modelSt[i] = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: every line Invalid after reset
    for (int i = 0; i < NL; i++) snoop(2'b01, i);

    // directed sequence through all states
    cpuAccess(1'b0, 0, 1'b0, 2);   // R4 fill E (R1 code 10)
    cpuAccess(1'b0, 0, 1'b1, 0);   // R2 read hit
    cpuAccess(1'b1, 0, 1'b0, 0);   // R3 E -> M silently
    cpuAccess(1'b1, 0, 1'b0, 0);   // R3 M stays M
    snoop(2'b01, 0);               // R7 M -> S with flush
    cpuAccess(1'b1, 0, 1'b0, 1);   // R6 upgrade
    snoop(2'b10, 0);               // R8 M -> I with flush
    cpuAccess(1'b1, 1, 1'b0, 0);   // R5 write miss
    cpuAccess(1'b0, 2, 1'b1, 3);   // R4 fill S
    snoop(2'b11, 2);               // R8 S -> I, no flush
    cpuAccess(1'b0, 3, 1'b0, 0);   // fill E
    snoop(2'b01, 3);               // R7 E -> S, no flush
    snoop(2'b01, 3);               // R7 S stays S
    snoop(2'b10, 5);               // R9 Invalid line

    // R10: collision of a write hit with a same-line snoop read
    cpuAccess(1'b0, 4, 1'b0, 0);   // line 4 in E
    @(negedge clk);
    cpuValid = 1; cpuWrite = 1; cpuLine = 3'd4;
    snpValid = 1; snpCmd = 2'b01; snpLine = 3'd4;
    #5;
    chk(cpuDone == 1'b0 && busCmd == 2'b00, "R10", {cpuDone, busCmd}, 0);
    chk(snpShared == 1'b1 && snpFlush == 1'b0, "R10", {snpShared, snpFlush}, 2);
    @(negedge clk); snpValid = 0; #5;
    chk(cpuDone == 1'b0 && busReq == 1'b0, "R10", {cpuDone, busReq}, 0);
    @(negedge clk);
    snpValid = 1; snpCmd = 2'b10; snpLine = 3'd4; #5;
    chk(busReq == 1'b1 && busCmd == 2'b00 && cpuDone == 1'b0, "R10",
        {busReq, busCmd, cpuDone}, 4'b1000);
    chk(snpFlush == 1'b0 && snpShared == 1'b0, "R10", {snpShared, snpFlush}, 0);
    @(negedge clk); snpValid = 0; busGnt = 1; #5;
    chk(busCmd == 2'b10, "R10", busCmd, 2);
    chk(cpuDone == 1'b1 && cpuState == 2'b11, "R10", {cpuDone, cpuState}, 3'b111);
    modelSt[4] = 2'b11;
    @(negedge clk); cpuValid = 0; busGnt = 0;

    // constrained random mix checked against the model
    begin
      int seedv;
      seedv = $urandom(32'h5eed);
    end
    for (int n = 0; n < 600; n++) begin
      int kind, line;
      kind = $urandom % 4;
      line = $urandom % NL;
      if (kind < 2)
        cpuAccess(kind[0], line, 1'($urandom % 2), $urandom % 4);
      else if (kind == 2)
        snoop(2'b01, line);
      else
        snoop(($urandom % 2) ? 2'b10 : 2'b11, line);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule